// File: doc/BRIEF.md
# Triple-Redundant Scan Register Word

This block is a word of storage bits in which every bit is held by three identical flip-flops that all load the same value on each rising clock edge. A two-input exclusive-OR compares two of the copies, and its result steers a 2:1 multiplexer. When the two copies agree, the multiplexer passes one of them. When they disagree, it passes the third copy. The voted value of each bit is therefore correct whenever no more than one of its three copies is wrong.

A scan enable replaces functional data with the serial scan path for all three copies of every bit at once. The voted output of one bit is the scan source of the next bit, so a single upset copy is also masked while the word is shifting. Each copy of each bit has a fault-injection input. A high level on that input at a clock edge makes that copy store the inverse of the value it would otherwise load. If the input is held high, it models a stuck fault. If it is pulsed for one edge, it models an upset.

The third copy only reaches the output when the other two disagree. When the word is healthy, that copy cannot be seen at the ports, so a defect in it stays hidden.

Top module: `tmr_scan_word`

## Requirements
- R1: While rst_ni is low, every copy is cleared asynchronously and data_o and scan_o read 0, even before any clock edge.
- R2: With scan_en_i low, data_o after a rising edge equals the data_i present at that edge.
- R3: With scan_en_i high, each rising edge shifts the word toward the MSB. Bit 0 loads scan_i, bit i loads the voted bit i-1 (LSB is bit 0), and scan_o always shows the voted bit WIDTH-1.
- R4: A high fault_a_i[i] at an edge inverts the value that copy A of bit i stores, and data_o is unchanged by it.
- R5: A high fault_b_i[i] at an edge inverts the value copy B of bit i stores, and data_o is unchanged by it.
- R6: A high fault_c_i[i] at an edge inverts the value copy C of bit i stores, and data_o is unchanged by it.
- R7: A fault input held high over many consecutive edges (stuck copy) is masked on every one of those edges.
- R8: Single-copy faults injected while scan_en_i is high do not alter the shifted data seen on data_o and scan_o.
- R9: Faults on different copies in different bits during the same edge, at most one copy per bit, are all masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | WIDTH | Functional data |
| scan_en_i | input | 1 | 1 selects the scan path for all copies |
| scan_i | input | 1 | Serial scan input into bit 0 |
| fault_a_i | input | WIDTH | Per-bit inversion of copy A on capture |
| fault_b_i | input | WIDTH | Per-bit inversion of copy B on capture |
| fault_c_i | input | WIDTH | Per-bit inversion of copy C on capture |
| data_o | output | WIDTH | Voted word |
| scan_o | output | 1 | Voted MSB, end of scan chain |

## Verification
Functional loads use all-zero, all-one, alternating and walking patterns, which separate stuck or swapped bit positions. Faults are put on copy A, B and C in turn. A fault on A or B forces the comparison to select C. A fault on C must leave the comparison at 0, so this pattern exposes a multiplexer with the wrong polarity or the wrong input. A held fault and a fault during shifting show that masking holds over time and along the chain. A mixed pattern, with one faulty copy per bit, shows that the bits vote independently.

// File: rtl/tmr_scan_pkg.sv
package tmr_scan_pkg;
  localparam int unsigned N_COPY = 3;
  typedef enum logic [1:0] {
    COPY_A = 2'd0,
    COPY_B = 2'd1,
    COPY_C = 2'd2
  } copy_e;
endpackage

// File: rtl/tmr_store.sv
module tmr_store (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic flip_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i ^ flip_i;
  end
endmodule

// File: rtl/tmr_vote.sv
module tmr_vote (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic y_o
);
  logic cmp;
  // disagreement between A and B hands the output to C
  assign cmp = a_i ^ b_i;
  assign y_o = cmp ? c_i : a_i;
endmodule

// File: rtl/tmr_scan_bit.sv
module tmr_scan_bit
  import tmr_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_i,
  input  logic              scan_i,
  input  logic              scan_en_i,
  input  logic [N_COPY-1:0] flip_i,
  output logic              q_o
);
  logic              d;
  logic [N_COPY-1:0] copy_q;

  assign d = scan_en_i ? scan_i : data_i;

  for (genvar k = 0; k < N_COPY; k++) begin : g_copy
    tmr_store u_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (d),
      .flip_i (flip_i[k]),
      .q_o    (copy_q[k])
    );
  end

  tmr_vote u_vote (
    .a_i (copy_q[COPY_A]),
    .b_i (copy_q[COPY_B]),
    .c_i (copy_q[COPY_C]),
    .y_o (q_o)
  );
endmodule

// File: rtl/tmr_scan_word.sv
module tmr_scan_word
  import tmr_scan_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             scan_en_i,
  input  logic             scan_i,
  input  logic [WIDTH-1:0] fault_a_i,
  input  logic [WIDTH-1:0] fault_b_i,
  input  logic [WIDTH-1:0] fault_c_i,
  output logic [WIDTH-1:0] data_o,
  output logic             scan_o
);
  localparam int unsigned CHAIN_LEN = WIDTH + 1;

  logic [CHAIN_LEN-1:0] chain;

  assign chain[0] = scan_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [N_COPY-1:0] flip;
    assign flip[COPY_A] = fault_a_i[i];
    assign flip[COPY_B] = fault_b_i[i];
    assign flip[COPY_C] = fault_c_i[i];

    tmr_scan_bit u_bit (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .data_i    (data_i[i]),
      .scan_i    (chain[i]),
      .scan_en_i (scan_en_i),
      .flip_i    (flip),
      .q_o       (chain[i+1])
    );
  end

  assign data_o = chain[CHAIN_LEN-1:1];
  assign scan_o = chain[CHAIN_LEN-1];
endmodule

// File: rtl/tmr_scan_chk.sv
module tmr_scan_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] data_i,
  input logic             scan_en_i,
  input logic             scan_i,
  input logic [WIDTH-1:0] data_o,
  input logic             scan_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (data_o == '0 && scan_o == 1'b0)); // R1

  AST_FUNC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !scan_en_i) |=> (data_o == $past(data_i))); // R2

  AST_SHIFT_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && scan_en_i) |=> (data_o[0] == $past(scan_i))); // R3

  if (WIDTH > 1) begin : g_body
    AST_SHIFT_BODY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && scan_en_i) |=> (data_o[WIDTH-1:1] == $past(data_o[WIDTH-2:0]))); // R3

    AST_SCAN_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && scan_en_i) |=> (scan_o == $past(data_o[WIDTH-2]))); // R8
  end
endmodule

bind tmr_scan_word tmr_scan_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_i    (data_i),
  .scan_en_i (scan_en_i),
  .scan_i    (scan_i),
  .data_o    (data_o),
  .scan_o    (scan_o)
);

// File: tb/tb_tmr_scan_word.sv
module tb_tmr_scan_word;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] data_in = '0;
  logic         sen = 1'b0;
  logic         sin = 1'b0;
  logic [W-1:0] fa = '0, fb = '0, fc = '0;
  logic [W-1:0] data_out;
  logic         scan_out;
  logic [W-1:0] exp_q = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_scan_word #(.WIDTH(W)) dut (
    .clk_i (clk), .rst_ni (rst_n), .data_i (data_in), .scan_en_i (sen),
    .scan_i (sin), .fault_a_i (fa), .fault_b_i (fb), .fault_c_i (fc),
    .data_o (data_out), .scan_o (scan_out)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, clock once, compare at the next negedge
  task automatic step(input string tag, input logic [W-1:0] d, input logic se,
                      input logic si, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic [W-1:0] c);
    data_in = d; sen = se; sin = si; fa = a; fb = b; fc = c;
    @(posedge clk);
    exp_q = se ? {exp_q[W-2:0], si} : d;
    @(negedge clk);
    check(tag, data_out, exp_q);
    check({tag, " scan_o"}, {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, exp_q[W-1]});
    fa = '0; fb = '0; fc = '0;
  endtask

  task automatic t_reset();
    check("R1 reset data_o", data_out, '0);
    check("R1 reset scan_o", {{(W-1){1'b0}}, scan_out}, '0);
    @(negedge clk); rst_n = 1'b1;
    step("R2 load", 8'hA5, 1'b0, 1'b0, '0, '0, '0);
    #2 rst_n = 1'b0; #1;
    exp_q = '0;
    check("R1 async clear", data_out, '0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_func();
    step("R2 zeros", 8'h00, 1'b0, 1'b0, '0, '0, '0);
    step("R2 ones", 8'hFF, 1'b0, 1'b0, '0, '0, '0);
    step("R2 alt", 8'h55, 1'b0, 1'b0, '0, '0, '0);
    step("R2 alt2", 8'hAA, 1'b0, 1'b0, '0, '0, '0);
    for (int i = 0; i < W; i++) step("R2 walk", 8'h01 << i, 1'b0, 1'b0, '0, '0, '0);
  endtask

  task automatic t_fault_each();
    step("R4 fault A", 8'h3C, 1'b0, 1'b0, 8'hFF, '0, '0);
    step("R4 fault A clear", 8'hC3, 1'b0, 1'b0, 8'h81, '0, '0);
    step("R5 fault B", 8'h96, 1'b0, 1'b0, '0, 8'hFF, '0);
    step("R5 fault B part", 8'h69, 1'b0, 1'b0, '0, 8'h0F, '0);
    step("R6 fault C", 8'h5A, 1'b0, 1'b0, '0, '0, 8'hFF);
    step("R6 fault C part", 8'hA5, 1'b0, 1'b0, '0, '0, 8'hF0);
  endtask

  task automatic t_stuck();
    for (int i = 0; i < 6; i++) step("R7 stuck B", 8'h11 * i[7:0], 1'b0, 1'b0, '0, 8'h24, '0);
    for (int i = 0; i < 6; i++) step("R7 stuck C", ~(8'h11 * i[7:0]), 1'b0, 1'b0, '0, '0, 8'hFF);
  endtask

  task automatic t_scan();
    logic [W-1:0] pat = 8'b1011_0010;
    step("R2 preload", 8'h00, 1'b0, 1'b0, '0, '0, '0);
    for (int i = 0; i < W; i++) step("R3 shift", '0, 1'b1, pat[i], '0, '0, '0);
    for (int i = 0; i < W; i++) step("R3 shift out", '0, 1'b1, 1'b0, '0, '0, '0);
  endtask

  task automatic t_scan_fault();
    step("R2 preload", 8'hE7, 1'b0, 1'b0, '0, '0, '0);
    for (int i = 0; i < W; i++) begin
      step("R8 scan fault A", '0, 1'b1, i[0], 8'h01 << i, '0, '0);
      step("R8 scan fault B", '0, 1'b1, i[1], '0, 8'hFF, '0);
      step("R8 scan fault C", '0, 1'b1, ~i[0], '0, '0, 8'hFF);
    end
  endtask

  task automatic t_mixed();
    step("R9 mixed", 8'hD2, 1'b0, 1'b0, 8'h49, 8'h92, 8'h24);
    step("R9 mixed2", 8'h2D, 1'b0, 1'b0, 8'h24, 8'h49, 8'h92);
    step("R9 mixed scan", '0, 1'b1, 1'b1, 8'h92, 8'h24, 8'h49);
  endtask

  initial begin
    #3;
    t_reset();
    t_func();
    t_fault_each();
    t_stuck();
    t_scan();
    t_scan_fault();
    t_mixed();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule